// File: doc/BRIEF.md
# SDR SDRAM controller with periodic refresh

This block drives one rank of 64-bit single-data-rate SDRAM, built from four x16 devices that share the command, bank and address lines and split the data bus into eight byte lanes. On the user side it takes one word read or write at a time through a req/ready handshake. Each write carries a byte-enable mask. Read data comes back with a one-cycle valid strobe. On the memory side it drives clock enable, chip select, the RAS/CAS/WE command lines, a two-bit bank address, the multiplexed row/column address, the eight byte-mask lines and a 64-bit write data bus with its own output enable.

After reset the controller holds the bus in NOP for the power-up wait. It then precharges every bank, issues two refreshes and loads the mode register. From then on it serves requests. Each access is closed-page: ACTIVE, then READ or WRITE with auto precharge, then a fixed recovery gap. A free-running timer raises a refresh request at the rate that a 4 ms retention budget needs. Once the bus is idle, that refresh takes priority over any waiting user request. CAS latency, ACTIVE-to-access delay and precharge time share one parameter, `LAT`, which is 2 or 3.

Top module: `sdram_ctrl`

## Requirements
- R1: From reset until the power-up wait of `INIT_US` microseconds (`INIT_US*CLK_MHZ` cycles) has elapsed, the controller issues only NOP. Clock enable is high, and `ready` and `init_done` are low.
- R2: The first command after the wait is PRECHARGE with A10 high. It is followed by two AUTO REFRESH commands and then LOAD MODE. LOAD MODE drives burst length 1 (A2..A0 = 000), sequential order (A3 = 0) and CAS latency `LAT` on A6..A4, with every other address bit 0. `init_done` rises no sooner than 2 cycles after LOAD MODE, and `ready` stays low until `init_done` is high.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R4: The user address is {bank[1:0], row[ROW_BITS-1:0], col[COL_BITS-1:0]}, with the bank in the top bits. ACTIVE drives the bank on BA and the row on A. READ and WRITE drive the same bank, put the column in the low A bits, and set A10 high to request auto precharge.
- R5: READ or WRITE follows its ACTIVE by exactly `LAT` cycles. The next command comes no sooner than `LAT+2` cycles after a READ or WRITE, `LAT` cycles after PRECHARGE, and 2 cycles after LOAD MODE.
- R6: The write data output enable is high only in the WRITE command cycle, and that cycle carries the write data. Lane i's mask bit is the inverse of byte enable i. Masked bytes keep their earlier contents.
- R7: During READ all mask bits are low. The returned word is the one the memory presents `LAT` cycles after it samples READ. `rvalid` is a one-cycle pulse on the `2*LAT+1`-th rising edge after the edge that accepted the request.
- R8: A request is taken on a rising edge where `req` and `ready` are both high. `ready` is low in the next cycle and stays low until the access and its recovery gap have finished. With no request, no ACTIVE is issued.
- R9: AUTO REFRESH is issued only when no bank is open, and the next command comes no sooner than `ceil(TRFC_NS*CLK_MHZ/1000)` cycles after it. The target interval is `(4000*CLK_MHZ)/2^ROW_BITS` cycles. Two consecutive refreshes are never more than that interval plus `2*LAT+4` cycles apart, including while requests are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2+ROW_BITS+COL_BITS | Word address {bank,row,col} |
| wdata | input | 64 | Write data |
| wbe | input | 8 | Write byte enables, bit i covers bits 8i+7..8i |
| ready | output | 1 | Controller can accept a request this cycle |
| rdata | output | 64 | Read data |
| rvalid | output | 1 | One-cycle read data strobe |
| init_done | output | 1 | Power-up sequence finished |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ROW_BITS | Multiplexed row/column/op-code address |
| sd_dqm | output | 8 | Byte lane masks |
| sd_dq_o | output | 64 | Write data to the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_o |
| sd_dq_i | input | 64 | Read data from the memory |

## Verification
The single-pulse check on `rvalid` and the rule that refresh is acknowledged only while it is pending both depend on two things: accesses are single-beat, and each access is separated from the next by its recovery gap. The handshake assertions assume that `req`, `we`, `addr`, `wdata` and `wbe` are stable across the accepting edge. The stimulus therefore changes every input only on falling edges and drives a request only after it has seen `ready` high. The bench's memory model returns read data exactly `LAT` cycles after the edge that samples READ, and presents it away from the capturing edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_INIT_REF_A,
        ST_INIT_REF_B,
        ST_INIT_MODE,
        ST_IDLE,
        ST_ACCESS
    } seq_st_e;

    localparam int TMRD_CYC = 2;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int REF_CYC = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_due
);
    localparam int CW = $clog2(REF_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == '0) begin
            d.cnt = CW'(REF_CYC - 1);
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
        d.due = (q.due & ~ref_ack) | (q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= CW'(REF_CYC - 1);
            q.due <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ref_due = q.due;

    // R9: a pending refresh stays pending until the sequencer takes it
    a_r9_due_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.due && !ref_ack) |=> q.due)
        else $error("refresh request dropped before service");

    // R9: the sequencer acknowledges only a pending refresh
    a_r9_ack_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> q.due)
        else $error("refresh acknowledged while none pending");

endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
    parameter int LAT = 2,
    parameter int DW  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_on_bus,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic [LAT-1:0] pipe;
        logic [DW-1:0]  data;
        logic           vld;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[LAT-2:0], rd_on_bus};
        d.vld  = q.pipe[LAT-1];
        if (q.pipe[LAT-1]) begin
            d.data = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.data;
    assign rvalid = q.vld;

    // R7: single-beat reads spaced by their recovery give one-cycle strobes
    a_r7_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld)
        else $error("rvalid held longer than one cycle");

endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
    import sdc_pkg::*;
#(
    parameter int LAT      = 2,
    parameter int ROW_BITS = 12,
    parameter int COL_BITS = 8,
    parameter int DW       = 64,
    parameter int INIT_CYC = 5000,
    parameter int RFC_CYC  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic                          we,
    input  logic [2+ROW_BITS+COL_BITS-1:0] addr,
    input  logic [DW-1:0]                 wdata,
    input  logic [DW/8-1:0]               wbe,
    input  logic                          ref_due,
    output logic                          ready,
    output logic                          init_done,
    output logic                          ref_ack,
    output sd_cmd_e                       cmd,
    output logic [1:0]                    ba,
    output logic [ROW_BITS-1:0]           a,
    output logic [DW/8-1:0]               dqm,
    output logic [DW-1:0]                 dq_o,
    output logic                          dq_oe
);
    localparam int AW = 2 + ROW_BITS + COL_BITS;
    localparam int NB = DW / 8;
    localparam int WW = $clog2(INIT_CYC + RFC_CYC + LAT + 4);

    typedef struct packed {
        seq_st_e         st;
        logic [WW-1:0]   wait_c;
        sd_cmd_e         cmd;
        logic [1:0]      ba;
        logic [ROW_BITS-1:0] a;
        logic [NB-1:0]   dqm;
        logic [DW-1:0]   dq;
        logic            oe;
        logic            done;
        logic            we;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [NB-1:0]   be;
    } seq_t;

    seq_t q, d;
    logic idle_free;

    assign idle_free = (q.st == ST_IDLE) && (q.wait_c == '0);
    assign ready     = idle_free && q.done && !ref_due;

    always_comb begin
        d       = q;
        d.cmd   = CMD_NOP;
        d.oe    = 1'b0;
        d.dqm   = '0;
        ref_ack = 1'b0;
        if (q.wait_c != '0) begin
            d.wait_c = q.wait_c - 1'b1;
        end else begin
            unique case (q.st)
                ST_POWER: begin
                    d.cmd    = CMD_PRE;
                    d.a      = '0;
                    d.a[10]  = 1'b1;
                    d.wait_c = WW'(LAT - 1);
                    d.st     = ST_INIT_REF_A;
                end
                ST_INIT_REF_A: begin
                    d.cmd    = CMD_REF;
                    d.wait_c = WW'(RFC_CYC - 1);
                    d.st     = ST_INIT_REF_B;
                end
                ST_INIT_REF_B: begin
                    d.cmd    = CMD_REF;
                    d.wait_c = WW'(RFC_CYC - 1);
                    d.st     = ST_INIT_MODE;
                end
                ST_INIT_MODE: begin
                    d.cmd    = CMD_MRS;
                    d.ba     = '0;
                    d.a      = '0;
                    d.a[6:4] = 3'(LAT);
                    d.wait_c = WW'(TMRD_CYC - 1);
                    d.st     = ST_IDLE;
                end
                ST_IDLE: begin
                    d.done = 1'b1;
                    if (q.done && ref_due) begin
                        d.cmd    = CMD_REF;
                        ref_ack  = 1'b1;
                        d.wait_c = WW'(RFC_CYC - 1);
                    end else if (req && ready) begin
                        d.we     = we;
                        d.addr   = addr;
                        d.wdata  = wdata;
                        d.be     = wbe;
                        d.cmd    = CMD_ACT;
                        d.ba     = addr[AW-1 -: 2];
                        d.a      = addr[COL_BITS +: ROW_BITS];
                        d.wait_c = WW'(LAT - 1);
                        d.st     = ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    d.cmd    = q.we ? CMD_WR : CMD_RD;
                    d.ba     = q.addr[AW-1 -: 2];
                    d.a      = '0;
                    d.a[COL_BITS-1:0] = q.addr[COL_BITS-1:0];
                    d.a[10]  = 1'b1;
                    if (q.we) begin
                        d.oe  = 1'b1;
                        d.dq  = q.wdata;
                        d.dqm = ~q.be;
                    end
                    d.wait_c = WW'(LAT + 1);
                    d.st     = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_POWER;
            q.wait_c <= WW'(INIT_CYC);
            q.cmd    <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign init_done = q.done;
    assign cmd       = q.cmd;
    assign ba        = q.ba;
    assign a         = q.a;
    assign dqm       = q.dqm;
    assign dq_o      = q.dq;
    assign dq_oe     = q.oe;

    // R4: every column access requests auto precharge
    a_r4_rw_autopre: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_RD || q.cmd == CMD_WR) |-> q.a[10])
        else $error("column access without auto precharge");

    // R5: ACTIVE is always followed by at least one NOP cycle
    a_r5_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_ACT) |=> (q.cmd == CMD_NOP))
        else $error("command issued right after ACTIVE");

    // R6: data bus driven only in a WRITE cycle
    a_r6_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.cmd == CMD_WR))
        else $error("data driven outside WRITE");

    // R8: the bus is quiet whenever a request could be taken
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (q.cmd == CMD_NOP))
        else $error("ready while a command is on the bus");

    // R8: accepting a request drops ready in the next cycle
    a_r8_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready)
        else $error("ready stayed high after accept");

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdc_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int LAT      = 2,
    parameter int ROW_BITS = 12,
    parameter int COL_BITS = 8,
    parameter int INIT_US  = 100,
    parameter int TRFC_NS  = 66
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req,
    input  logic                           we,
    input  logic [2+ROW_BITS+COL_BITS-1:0] addr,
    input  logic [63:0]                    wdata,
    input  logic [7:0]                     wbe,
    output logic                           ready,
    output logic [63:0]                    rdata,
    output logic                           rvalid,
    output logic                           init_done,
    output logic                           sd_cke,
    output logic                           sd_cs_n,
    output logic                           sd_ras_n,
    output logic                           sd_cas_n,
    output logic                           sd_we_n,
    output logic [1:0]                     sd_ba,
    output logic [ROW_BITS-1:0]            sd_a,
    output logic [7:0]                     sd_dqm,
    output logic [63:0]                    sd_dq_o,
    output logic                           sd_dq_oe,
    input  logic [63:0]                    sd_dq_i
);
    localparam int DW       = 64;
    localparam int INIT_CYC = INIT_US * CLK_MHZ;
    localparam int REF_CNT  = 1 << ROW_BITS;
    localparam int REF_CYC  = (4000 * CLK_MHZ) / REF_CNT;
    localparam int RFC_CYC  = ceil_div(TRFC_NS * CLK_MHZ, 1000);

    sd_cmd_e cmd;
    logic    ref_due;
    logic    ref_ack;

    sdc_refresh_timer #(.REF_CYC(REF_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_ack (ref_ack),
        .ref_due (ref_due)
    );

    sdc_sequencer #(
        .LAT      (LAT),
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DW       (DW),
        .INIT_CYC (INIT_CYC),
        .RFC_CYC  (RFC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .wbe       (wbe),
        .ref_due   (ref_due),
        .ready     (ready),
        .init_done (init_done),
        .ref_ack   (ref_ack),
        .cmd       (cmd),
        .ba        (sd_ba),
        .a         (sd_a),
        .dqm       (sd_dqm),
        .dq_o      (sd_dq_o),
        .dq_oe     (sd_dq_oe)
    );

    sdc_read_capture #(.LAT(LAT), .DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_on_bus (cmd == CMD_RD),
        .dq_i      (sd_dq_i),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;

endmodule

// File: tb/tb_sdram_ctrl.sv
module tb_sdram_ctrl;
    localparam int CLK_MHZ  = 50;
    localparam int LAT      = 2;
    localparam int ROW_BITS = 12;
    localparam int COL_BITS = 8;
    localparam int INIT_US  = 100;
    localparam int TRFC_NS  = 66;
    localparam int AW       = 2 + ROW_BITS + COL_BITS;
    localparam int INIT_CYC = INIT_US * CLK_MHZ;
    localparam int REF_CYC  = (4000 * CLK_MHZ) / (1 << ROW_BITS);
    localparam int RFC_CYC  = (TRFC_NS * CLK_MHZ + 999) / 1000;
    localparam int REF_SLACK = 2 * LAT + 4;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [7:0] wbe = '0;
    logic ready, rvalid, init_done;
    logic [63:0] rdata;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba;
    logic [ROW_BITS-1:0] sd_a;
    logic [7:0] sd_dqm;
    logic [63:0] sd_dq_o;
    logic [63:0] sd_dq_i = '0;

    always #10 clk = ~clk;

    sdram_ctrl #(.CLK_MHZ(CLK_MHZ), .LAT(LAT), .ROW_BITS(ROW_BITS),
                 .COL_BITS(COL_BITS), .INIT_US(INIT_US), .TRFC_NS(TRFC_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .wbe(wbe), .ready(ready), .rdata(rdata),
        .rvalid(rvalid), .init_done(init_done), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    int nvec = 0;
    int nbad = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // ---------------- memory device model (acts at falling edges) --------
    logic [63:0] dev_mem [logic [AW-1:0]];
    logic [63:0] exp_mem [logic [AW-1:0]];
    logic [63:0] rd_pipe [0:LAT];
    logic [3:0]  open_bank = '0;
    logic [ROW_BITS-1:0] open_row [0:3];
    int cyc = 0, init_step = 0, earliest = 0, last_act = 0;
    int last_ref = -1, mrs_cyc = 0, ref_total = 0, act_total = 0;
    bit seen_done = 1'b0;

    initial for (int k = 0; k <= LAT; k++) rd_pipe[k] = '0;

    always @(negedge clk) begin
        logic [3:0] c;
        logic [AW-1:0] key;
        logic [63:0] cur;
        if (rst_n) begin
            cyc++;
            for (int k = LAT; k > 0; k--) rd_pipe[k] = rd_pipe[k-1];
            rd_pipe[0] = '0;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (init_done && !seen_done) begin
                seen_done = 1'b1;
                chk(init_step == 4 && cyc - mrs_cyc >= 2, "R2 init_done timing",
                    64'(cyc - mrs_cyc), 64'd2);
            end
            if (!init_done) chk(!ready, "R2 ready low before init_done", 64'(ready), 64'd0);
            chk(sd_cke, "R1 clock enable high", 64'(sd_cke), 64'd1);
            if (c != C_NOP) begin
                chk(sd_dq_oe == (c == C_WR), "R6 output enable only on WRITE",
                    64'(sd_dq_oe), 64'(c == C_WR));
                if (init_step > 0)
                    chk(cyc >= earliest, "R5 command spacing", 64'(cyc), 64'(earliest));
                case (c)
                    C_PRE: begin
                        chk(init_step == 0 && sd_a[10], "R2 precharge-all first",
                            64'(init_step), 64'd0);
                        chk(cyc > INIT_CYC, "R1 power-up wait", 64'(cyc), 64'(INIT_CYC));
                        init_step = 1;
                        earliest = cyc + LAT;
                    end
                    C_REF: begin
                        if (init_step < 3) begin
                            chk(init_step == 1 || init_step == 2, "R2 init refresh order",
                                64'(init_step), 64'd1);
                            init_step++;
                        end else begin
                            ref_total++;
                            if (last_ref >= 0)
                                chk(cyc - last_ref <= REF_CYC + REF_SLACK, "R9 refresh gap",
                                    64'(cyc - last_ref), 64'(REF_CYC + REF_SLACK));
                        end
                        chk(open_bank == '0, "R9 refresh with banks idle",
                            64'(open_bank), 64'd0);
                        last_ref = cyc;
                        earliest = cyc + RFC_CYC;
                    end
                    C_MRS: begin
                        chk(init_step == 3, "R2 mode load after two refreshes",
                            64'(init_step), 64'd3);
                        chk(sd_a == ROW_BITS'(LAT << 4), "R2 mode word",
                            64'(sd_a), 64'(LAT << 4));
                        init_step = 4;
                        mrs_cyc = cyc;
                        earliest = cyc + 2;
                    end
                    C_ACT: begin
                        act_total++;
                        chk(init_done && !open_bank[sd_ba], "R8 ACTIVE to idle bank after init",
                            64'(open_bank), 64'd0);
                        open_bank[sd_ba] = 1'b1;
                        open_row[sd_ba] = sd_a;
                        last_act = cyc;
                        earliest = cyc + LAT;
                    end
                    C_RD, C_WR: begin
                        chk(open_bank[sd_ba] && cyc - last_act == LAT, "R5 ACTIVE to access",
                            64'(cyc - last_act), 64'(LAT));
                        chk(sd_a[10], "R4 auto precharge bit", 64'(sd_a[10]), 64'd1);
                        key = {sd_ba, open_row[sd_ba], sd_a[COL_BITS-1:0]};
                        cur = dev_mem.exists(key) ? dev_mem[key] : 64'd0;
                        if (c == C_WR) begin
                            for (int b = 0; b < 8; b++)
                                if (!sd_dqm[b]) cur[b*8 +: 8] = sd_dq_o[b*8 +: 8];
                            dev_mem[key] = cur;
                        end else begin
                            chk(sd_dqm == 8'h00, "R7 masks low on READ", 64'(sd_dqm), 64'd0);
                            rd_pipe[0] = cur;
                        end
                        open_bank[sd_ba] = 1'b0;
                        earliest = cyc + LAT + 2;
                    end
                    default: chk(1'b0, "R3 unknown command code", 64'(c), 64'(C_NOP));
                endcase
            end
            sd_dq_i <= rd_pipe[LAT];
        end
    end

    // ---------------- user-side tasks --------------------------------------
    function automatic logic [AW-1:0] mk(input int b, input int r, input int c);
        return {2'(b), ROW_BITS'(r), COL_BITS'(c)};
    endfunction

    task automatic do_write(input logic [AW-1:0] ad, input logic [63:0] d, input logic [7:0] be);
        logic [63:0] cur;
        while (!ready) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = ad; wdata = d; wbe = be;
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R8 ready low after accept", 64'(ready), 64'd0);
        cur = exp_mem.exists(ad) ? exp_mem[ad] : 64'd0;
        for (int b = 0; b < 8; b++) if (be[b]) cur[b*8 +: 8] = d[b*8 +: 8];
        exp_mem[ad] = cur;
    endtask

    task automatic do_read(input logic [AW-1:0] ad, input string tag);
        int lat;
        logic [63:0] e;
        while (!ready) @(negedge clk);
        req = 1'b1; we = 1'b0; addr = ad;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!rvalid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat - 1 == 2 * LAT + 1, "R7 rvalid latency", 64'(lat - 1), 64'(2 * LAT + 1));
        e = exp_mem.exists(ad) ? exp_mem[ad] : 64'd0;
        chk(rdata === e, tag, rdata, e);
        @(negedge clk);
        chk(!rvalid, "R7 rvalid single pulse", 64'(rvalid), 64'd0);
    endtask

    // ---------------- watchdog -------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    // ---------------- main sequence --------------------------------------
    initial begin
        int rows [4];
        int cols [4];
        int acts0, refs0;
        rows = '{0, 1, 2730, (1 << ROW_BITS) - 1};
        cols = '{0, 1, 1 << (COL_BITS - 1), (1 << COL_BITS) - 1};

        repeat (4) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !ready && !init_done && sd_cke,
            "R1 reset state", 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(C_NOP));
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !init_done,
            "R1 NOP during power-up wait", 64'(init_done), 64'd0);
        while (!init_done) @(negedge clk);

        // R4 R6 R7: full-word sweep over banks, row and column extremes
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    do_write(mk(b, rows[r], cols[c]),
                             64'(mk(b, rows[r], cols[c])) * 64'h9E37_79B9_7F4A_7C15, 8'hFF);
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    do_read(mk(b, rows[r], cols[c]), "R4 address mapping readback");

        // R6: every byte-enable pattern on one word
        do_write(mk(2, 77, 5), 64'h0123_4567_89AB_CDEF, 8'hFF);
        for (int m = 0; m < 256; m++) begin
            do_write(mk(2, 77, 5), {8{8'(m)}} ^ 64'hA5C3_0F96_5A3C_F069, 8'(m));
            do_read(mk(2, 77, 5), "R6 byte mask merge");
        end

        // R8 R9: idle bus keeps refreshing and never activates a row
        acts0 = act_total;
        refs0 = ref_total;
        repeat (300) @(negedge clk);
        chk(act_total == acts0, "R8 no ACTIVE without request",
            64'(act_total - acts0), 64'd0);
        chk(ref_total - refs0 >= 300 / REF_CYC - 1, "R9 refreshes while idle",
            64'(ref_total - refs0), 64'(300 / REF_CYC - 1));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule